// File: doc/BRIEF.md
# Iterative CORDIC sine and cosine register peripheral

This block offloads sine and cosine evaluation from a processor. Software writes an angle word to one register, polls a status bit, then reads the two results from two more registers. Inside, a single shift-and-add datapath runs the CORDIC rotation algorithm one micro-rotation per clock. The same adders and shifters are reused for every step, so the block stays small at the cost of one result every 17 cycles.

The angle is a signed binary fraction of a half turn. The full 32-bit range spans -π to +π, so 0x4000_0000 is +π/2 and 0x8000_0000 is -π. Only the upper 16 bits take part in the arithmetic. Angles whose magnitude exceeds π/2 are first turned by a half turn, and the two results are negated at the end. The x register starts at the reciprocal of the CORDIC gain, so the results need no scaling afterwards. They come out in Q1.15 format.

Top module: `cordic_sincos_periph`

## Requirements
- R1: After a run, the cosine (offset 0x08) and sine (offset 0x0C) readings lie within 40 LSB of round(32768·cos θ) and round(32768·sin θ). θ is the signed value of angle bits 31:16 times π/32768.
- R2: A write to offset 0x04 starts a run. A read of offset 0x00 returns the done flag in bit 0, and bits 31:1 read as zero.
- R3: Results are 16-bit Q1.15 values, sign-extended to 32 bits: bits 31:16 of a result read equal its bit 15.
- R4: Call the edge that samples the angle write edge 0. Status bit 0 reads 0 after edges 0 through 16 and reads 1 after edge 17.
- R5: Angle bits 15:0 have no effect on the results.
- R6: Angles with a magnitude above π/2, including exactly -π and nearly +π, converge to correct results, for example cos(-π) ≈ -1.
- R7: One setup cycle is followed by exactly 16 iteration cycles, counted by an iteration index that stays below 16 while iterating.
- R8: The done flag stays set while idle until the next angle write, which clears it from edge 0 of that write.
- R9: Reads of any offset other than 0x00, 0x08 and 0x0C return zero. This includes the write-only angle offset 0x04.
- R10: Angle writes while a run is in progress, and writes to any offset other than 0x04, have no effect on the timing or the results.
- R11: After reset the status, cosine and sine registers all read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 6 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 32 | Write data (angle word) |
| rdata | output | 32 | Read data for the register at `addr`, combinational |

## Verification
The checker assumes that `addr` is stable and that `wr_en` is a clean single-cycle strobe at each rising edge. It also assumes that reset is held from time zero, so the control state is known before the first sampled edge. The bench drives every input at the falling edge and returns `wr_en` low after each access. Its stray writes land only on cycles it has chosen, either inside a run or against the read-only result offsets. Random angles are drawn over the whole 32-bit word, so every quadrant and the half-turn pre-rotation are reached without breaking those assumptions.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int CALC_W = 16;
  localparam int N_ITER = 16;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_ANGLE  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_COS    = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_SIN    = 6'h0C;

  // reciprocal CORDIC gain in Q1.15, trimmed slightly below 0.60725 for headroom
  localparam logic [CALC_W-1:0] INV_GAIN_Q15 = 16'd19890;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } cordic_state_e;

endpackage

// File: rtl/cordic_rst_sync.sv
module cordic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom #(
  parameter int CALC_W = cordic_pkg::CALC_W,
  parameter int CNT_W  = 5
) (
  input  logic [CNT_W-1:0]  idx,
  output logic [CALC_W-1:0] atan_o
);

  // arctan(2^-i) in units where 2^(CALC_W-2) equals pi/2
  always_comb begin
    case (idx)
      CNT_W'(0):  atan_o = CALC_W'(8192);
      CNT_W'(1):  atan_o = CALC_W'(4836);
      CNT_W'(2):  atan_o = CALC_W'(2555);
      CNT_W'(3):  atan_o = CALC_W'(1297);
      CNT_W'(4):  atan_o = CALC_W'(651);
      CNT_W'(5):  atan_o = CALC_W'(326);
      CNT_W'(6):  atan_o = CALC_W'(163);
      CNT_W'(7):  atan_o = CALC_W'(81);
      CNT_W'(8):  atan_o = CALC_W'(41);
      CNT_W'(9):  atan_o = CALC_W'(20);
      CNT_W'(10): atan_o = CALC_W'(10);
      CNT_W'(11): atan_o = CALC_W'(5);
      CNT_W'(12): atan_o = CALC_W'(3);
      CNT_W'(13): atan_o = CALC_W'(1);
      CNT_W'(14): atan_o = CALC_W'(1);
      default:    atan_o = '0;
    endcase
  end

endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl #(
  parameter int N_ITER = cordic_pkg::N_ITER,
  parameter int CNT_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output cordic_pkg::cordic_state_e state_o,
  output logic [CNT_W-1:0]         iter_o,
  output logic                     load_o,
  output logic                     step_o,
  output logic                     finish_o
);
  import cordic_pkg::*;

  localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(N_ITER - 1);

  cordic_state_e    state_q, state_d;
  logic [CNT_W-1:0] iter_q, iter_d;

  always_comb begin
    state_d = state_q;
    iter_d  = iter_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_BUSY;
          iter_d  = '0;
        end
      end
      ST_BUSY: begin
        iter_d = iter_q + CNT_W'(1);
        if (iter_q == LAST_ITER) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
    end else begin
      state_q <= state_d;
      iter_q  <= iter_d;
    end
  end

  assign state_o  = state_q;
  assign iter_o   = iter_q;
  assign load_o   = (state_q == ST_IDLE) && start;
  assign step_o   = (state_q == ST_BUSY);
  assign finish_o = (state_q == ST_DONE);

endmodule

// File: rtl/cordic_datapath.sv
module cordic_datapath #(
  parameter int CALC_W = cordic_pkg::CALC_W,
  parameter int CNT_W  = 5,
  parameter logic [CALC_W-1:0] INV_GAIN = cordic_pkg::INV_GAIN_Q15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     step,
  input  logic [CALC_W-1:0]        angle_hi,
  input  logic [CNT_W-1:0]         iter,
  input  logic [CALC_W-1:0]        atan_val,
  output logic signed [CALC_W-1:0] x_o,
  output logic signed [CALC_W-1:0] y_o,
  output logic                     flip_o
);

  logic signed [CALC_W-1:0] x_q, y_q;
  logic        [CALC_W-1:0] z_q;
  logic                     flip_q;

  logic signed [CALC_W-1:0] x_sh, y_sh, x_nx, y_nx;
  logic        [CALC_W-1:0] z_nx, z_init;
  logic                     outer, rot_pos;

  // angles in the two outer quadrants are turned by a half turn
  assign outer  = angle_hi[CALC_W-1] ^ angle_hi[CALC_W-2];
  assign z_init = outer ? {~angle_hi[CALC_W-1], angle_hi[CALC_W-2:0]} : angle_hi;

  assign x_sh    = x_q >>> iter;
  assign y_sh    = y_q >>> iter;
  assign rot_pos = ~z_q[CALC_W-1];

  always_comb begin
    if (rot_pos) begin
      x_nx = x_q - y_sh;
      y_nx = y_q + x_sh;
      z_nx = z_q - atan_val;
    end else begin
      x_nx = x_q + y_sh;
      y_nx = y_q - x_sh;
      z_nx = z_q + atan_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      flip_q <= 1'b0;
    end else if (load) begin
      x_q    <= INV_GAIN;
      y_q    <= '0;
      z_q    <= z_init;
      flip_q <= outer;
    end else if (step) begin
      x_q <= x_nx;
      y_q <= y_nx;
      z_q <= z_nx;
    end
  end

  assign x_o    = x_q;
  assign y_o    = y_q;
  assign flip_o = flip_q;

endmodule

// File: rtl/cordic_regs.sv
module cordic_regs #(
  parameter int ADDR_W = cordic_pkg::ADDR_W,
  parameter int DATA_W = cordic_pkg::DATA_W,
  parameter int CALC_W = cordic_pkg::CALC_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     finish,
  input  logic signed [CALC_W-1:0] x_in,
  input  logic signed [CALC_W-1:0] y_in,
  input  logic                     flip,
  input  logic [ADDR_W-1:0]        addr,
  output logic [DATA_W-1:0]        rdata,
  output logic                     done_o
);
  import cordic_pkg::*;

  localparam int EXT_W = DATA_W - CALC_W;

  logic signed [CALC_W-1:0] cos_q, sin_q;
  logic                     done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cos_q  <= '0;
      sin_q  <= '0;
      done_q <= 1'b0;
    end else if (finish) begin
      cos_q  <= flip ? -x_in : x_in;
      sin_q  <= flip ? -y_in : y_in;
      done_q <= 1'b1;
    end else if (load) begin
      done_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      OFS_STATUS: rdata = {{(DATA_W-1){1'b0}}, done_q};
      OFS_COS:    rdata = {{EXT_W{cos_q[CALC_W-1]}}, cos_q};
      OFS_SIN:    rdata = {{EXT_W{sin_q[CALC_W-1]}}, sin_q};
      default:    rdata = '0;
    endcase
  end

  assign done_o = done_q;

endmodule

// File: rtl/cordic_sincos_periph.sv
module cordic_sincos_periph #(
  parameter int ADDR_W = cordic_pkg::ADDR_W,
  parameter int DATA_W = cordic_pkg::DATA_W,
  parameter int CALC_W = cordic_pkg::CALC_W,
  parameter int N_ITER = cordic_pkg::N_ITER
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import cordic_pkg::*;

  localparam int CNT_W = $clog2(N_ITER) + 1;

  logic                     rst_sync_n;
  logic                     start, load, step, finish, flip, done_q;
  cordic_state_e            state;
  logic [CNT_W-1:0]         iter;
  logic [CALC_W-1:0]        atan_val;
  logic signed [CALC_W-1:0] x_cur, y_cur;
  logic                     unused_low_bits;

  assign start           = wr_en && (addr == OFS_ANGLE);
  assign unused_low_bits = ^wdata[DATA_W-CALC_W-1:0];

  cordic_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cordic_ctrl #(.N_ITER(N_ITER), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .state_o  (state),
    .iter_o   (iter),
    .load_o   (load),
    .step_o   (step),
    .finish_o (finish)
  );

  cordic_atan_rom #(.CALC_W(CALC_W), .CNT_W(CNT_W)) u_rom (
    .idx    (iter),
    .atan_o (atan_val)
  );

  cordic_datapath #(.CALC_W(CALC_W), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (load),
    .step     (step),
    .angle_hi (wdata[DATA_W-1:DATA_W-CALC_W]),
    .iter     (iter),
    .atan_val (atan_val),
    .x_o      (x_cur),
    .y_o      (y_cur),
    .flip_o   (flip)
  );

  cordic_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CALC_W(CALC_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (load),
    .finish (finish),
    .x_in   (x_cur),
    .y_in   (y_cur),
    .flip   (flip),
    .addr   (addr),
    .rdata  (rdata),
    .done_o (done_q)
  );

endmodule

// File: rtl/cordic_sincos_chk.sv
module cordic_sincos_chk #(
  parameter int ADDR_W = cordic_pkg::ADDR_W,
  parameter int DATA_W = cordic_pkg::DATA_W,
  parameter int N_ITER = cordic_pkg::N_ITER,
  parameter int CNT_W  = $clog2(cordic_pkg::N_ITER) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      wr_en,
  input  logic [DATA_W-1:0]         rdata,
  input  cordic_pkg::cordic_state_e state,
  input  logic [CNT_W-1:0]          iter,
  input  logic                      done
);
  import cordic_pkg::*;

  logic start_w, mapped;
  assign start_w = wr_en && (addr == OFS_ANGLE);
  assign mapped  = (addr == OFS_STATUS) || (addr == OFS_COS) || (addr == OFS_SIN);

  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY) |-> (iter < CNT_W'(N_ITER)));                      // R7

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start_w) |=> (state == ST_BUSY && iter == '0 && !done)); // R4

  AST_LAST_ITER: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && iter == CNT_W'(N_ITER - 1)) |=> (state == ST_DONE)); // R7

  AST_BUSY_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY) |=> (state == ST_DONE || iter == $past(iter) + CNT_W'(1))); // R10

  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> (state == ST_IDLE && done));                   // R8

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_w) |=> done);                                         // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!mapped) |-> (rdata == '0));                                         // R9

  AST_STATUS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_STATUS) |-> (rdata[DATA_W-1:1] == '0));                  // R2

endmodule

bind cordic_sincos_periph cordic_sincos_chk u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .addr  (addr),
  .wr_en (wr_en),
  .rdata (rdata),
  .state (state),
  .iter  (iter),
  .done  (done_q)
);

// File: tb/cordic_sincos_periph_test.sv
module cordic_sincos_periph_test;

  localparam int TOL = 40;
  localparam int WATCHDOG = 150000;

  logic        clk;
  logic        rst_n;
  logic [5:0]  addr;
  logic        wr_en;
  logic [31:0] wdata;
  logic [31:0] rdata;

  int total_cnt = 0;
  int bad_cnt   = 0;
  int cyc       = 0;

  cordic_sincos_periph uut (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wr_en (wr_en),
    .wdata (wdata),
    .rdata (rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      bad_cnt = bad_cnt + 1;
      total_cnt = total_cnt + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", cyc, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total_cnt, bad_cnt);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total_cnt++;
    if (!ok) begin
      bad_cnt++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int model(input logic [31:0] a, input bit want_sin);
    real th, v;
    int  r;
    th = $itor($signed(a[31:16])) * 3.14159265358979 / 32768.0;
    v  = want_sin ? $sin(th) : $cos(th);
    r  = $rtoi(v * 32768.0 + ((v >= 0.0) ? 0.5 : -0.5));
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic int absi(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b0;
    addr  = a;
    #1 d = rdata;
  endtask

  // run one angle; checks latency, sign extension and accuracy
  task automatic run_angle(input logic [31:0] a, input bit inject, output int c, output int s);
    logic [31:0] d;
    @(negedge clk);
    addr = 6'h04; wdata = a; wr_en = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= 17; k++) begin
      if (k > 0) @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; addr = 6'h00; wdata = 32'h0;
      #1 chk(rdata === {31'b0, (k == 17)}, (k == 0) ? "R8 clear" : "R4 latency", rdata, (k == 17));
      if (inject && k == 3) begin
        addr = 6'h04; wdata = ~a; wr_en = 1'b1;   // R10: ignored angle write
      end
      if (inject && k == 5) begin
        addr = 6'h08; wdata = 32'h5A5A_5A5A; wr_en = 1'b1;  // R10: write to result offset
      end
    end
    rd(6'h08, d);
    chk(d[31:16] === {16{d[15]}}, "R3 cos sign ext", d[31:16], {16{d[15]}});
    c = $signed(d[15:0]);
    rd(6'h0C, d);
    chk(d[31:16] === {16{d[15]}}, "R3 sin sign ext", d[31:16], {16{d[15]}});
    s = $signed(d[15:0]);
    chk(absi(c - model(a, 1'b0)) <= TOL, "R1 cos", c, model(a, 1'b0));
    chk(absi(s - model(a, 1'b1)) <= TOL, "R1 sin", s, model(a, 1'b1));
    rd(6'h00, d);
    rd(6'h00, d);
    chk(d === 32'h1, "R8 sticky done", d, 1);
  endtask

  initial begin
    logic [31:0] d;
    int c, s, c2, s2;
    void'($urandom(32'd20250611));
    rst_n = 1'b0; addr = 6'h00; wr_en = 1'b0; wdata = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    rd(6'h00, d); chk(d === 32'h0, "R11 status", d, 0);
    rd(6'h08, d); chk(d === 32'h0, "R11 cos", d, 0);
    rd(6'h0C, d); chk(d === 32'h0, "R11 sin", d, 0);

    // directed: zero, quarter turns, half turn both ends, eighth turn
    run_angle(32'h0000_0000, 1'b0, c, s);
    run_angle(32'h4000_0000, 1'b0, c, s);
    run_angle(32'hC000_0000, 1'b0, c, s);
    run_angle(32'h8000_0000, 1'b1, c, s);
    chk(c < -32000, "R6 cos(-pi)", c, -32768);
    run_angle(32'h7FFF_FFFF, 1'b0, c, s);
    chk(c < -32000, "R6 cos(~+pi)", c, -32767);
    run_angle(32'h6000_0000, 1'b1, c, s);
    chk(c < 0 && s > 0, "R6 second quadrant signs", c, -23170);
    run_angle(32'h2000_0000, 1'b1, c, s);

    // R5: low half of the angle word is ignored
    run_angle(32'h1234_0000, 1'b0, c, s);
    run_angle(32'h1234_FFFF, 1'b0, c2, s2);
    chk(c == c2, "R5 cos low bits", c2, c);
    chk(s == s2, "R5 sin low bits", s2, s);

    // R9: unmapped and write-only offsets read zero
    rd(6'h04, d); chk(d === 32'h0, "R9 angle offset", d, 0);
    rd(6'h10, d); chk(d === 32'h0, "R9 offset 0x10", d, 0);
    rd(6'h3C, d); chk(d === 32'h0, "R9 offset 0x3C", d, 0);
    rd(6'h09, d); chk(d === 32'h0, "R9 offset 0x09", d, 0);

    // R10: writes to result offsets while idle change nothing
    @(negedge clk); addr = 6'h0C; wdata = 32'hFFFF_0000; wr_en = 1'b1;
    @(negedge clk); addr = 6'h00; wdata = 32'h1; wr_en = 1'b1;
    rd(6'h0C, d); chk($signed(d[15:0]) == s2, "R10 sin untouched", $signed(d[15:0]), s2);
    rd(6'h00, d); chk(d === 32'h1, "R10 status untouched", d, 1);

    // random angles over the whole circle
    for (int n = 0; n < 40; n++) begin
      run_angle($urandom, (n % 4) == 0, c, s);
    end

    $display("  test done: total=%0d bad=%0d", total_cnt, bad_cnt);
    $finish;
  end

endmodule